// File: doc/BRIEF.md
# Character Display Address Counter

This block keeps the write address for a two-line character display controller. Decoded instruction strobes arrive with their fields already split out. They can load an address into the display, character-pattern or icon RAM, clear the display, return home, change the entry mode, move the cursor or the view, or pick the line layout. Each RAM write then steps the address up or down, following the memory map of the selected RAM and the current line layout.

In two-line layout the display memory is split into two 40-entry windows, 0x00..0x27 and 0x40..0x67. Stepping jumps across the gap between them instead of counting through it. The block also holds the horizontal view offset. Screen-shift instructions change it, and so do display writes made with auto-shift enabled. The RAM arrays, the pixel drivers and the busy timing sit outside the block.

The reset input is asynchronous and active low. Its release passes through a two-flop synchroniser, so the block leaves reset on the second rising clock edge after `rst_n` goes high. All state changes on the rising edge that samples a strobe, and the outputs show the new value after that edge.

Top module: `chardisp_addr_unit`

## Requirements
- R1: After reset the address is 0, the target select is display (code 0), the step direction is up (1), auto-shift is off, the layout is one-line and the view offset is 0.
- R2: A display address-set loads all 7 bits of `set_val` and selects code 0. A pattern address-set loads `set_val[5:0]` and selects code 1. An icon address-set loads `set_val[3:0]` and selects code 2. The select changes only on an address-set, clear or home.
- R3: In one-line layout, a display write steps the address through 0x00..0x4F. Stepping up from 0x4F gives 0x00, and stepping down from 0x00 gives 0x4F.
- R4: In two-line layout, a display write steps up from 0x27 to 0x40 and from 0x67 to 0x00. It steps down from 0x40 to 0x27 and from 0x00 to 0x67. Every other address moves by one.
- R5: In double-height layout (double-height set, two-line clear), display addresses cycle through 0x00..0x27 in both directions.
- R6: Pattern RAM addresses step modulo 64 and icon RAM addresses step modulo 16. The direction comes from `step_up`.
- R7: Clear sets the address to 0, the direction to up, the target to display and the offset to 0. Home does the same, except that it leaves the direction unchanged.
- R8: With auto-shift on, each display write also moves the offset: up by one when the direction is up, down by one when it is down. The offset wraps within 0..39 in two-line or double-height layout and within 0..79 otherwise. Writes to pattern or icon RAM do not move the offset.
- R9: A screen-shift instruction adds 1 to the offset for left and subtracts 1 for right, wrapping as in R8. It leaves the address unchanged.
- R10: A cursor-shift instruction steps the address up for right and down for left, using the rules of R3 to R6. It leaves the offset unchanged.
- R11: A layout instruction sets the two-line and double-height flags and clears the offset. Two-line takes precedence when both flags are set.
- R12: Only one strobe acts per cycle. The order is clear, home, display set, pattern set, icon set, entry, shift, layout, and a RAM write acts only in a cycle with no instruction strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_disp_stb | input | 1 | Display address-set strobe |
| set_pat_stb | input | 1 | Pattern address-set strobe |
| set_icon_stb | input | 1 | Icon address-set strobe |
| set_val | input | 7 | Address field of the address-set strobes |
| clear_stb | input | 1 | Clear-display strobe |
| home_stb | input | 1 | Return-home strobe |
| entry_stb | input | 1 | Entry-mode strobe |
| entry_up | input | 1 | Entry field: 1 steps up |
| entry_shift | input | 1 | Entry field: 1 enables auto-shift |
| move_stb | input | 1 | Cursor/screen shift strobe |
| move_screen | input | 1 | 1 shifts the view, 0 moves the cursor |
| move_right | input | 1 | 1 right, 0 left |
| mode_stb | input | 1 | Layout strobe |
| mode_two_line | input | 1 | Layout field: two-line |
| mode_dbl | input | 1 | Layout field: double height |
| wr_stb | input | 1 | RAM write strobe |
| addr | output | 7 | Current address |
| ram_sel | output | 2 | Target RAM: 0 display, 1 pattern, 2 icon |
| step_up | output | 1 | Entry direction, 1 means up |
| view_ofs | output | 7 | Display view offset |

## Verification
A display write with auto-shift enabled changes both the address and the view offset on the same edge. The bench sets the address to the line seams 0x27 and 0x40 and writes in each direction, then checks both outputs one cycle later against offsets it tracks itself. The bench also drives an instruction strobe together with a write, and another address-set together with the display set, in the same cycle. The outputs must match the higher-priority action alone, with the write discarded.

// File: rtl/cdau_pkg.sv
`timescale 1ns/1ps
package cdau_pkg;

  typedef enum logic [1:0] {
    SEL_DISP = 2'd0,
    SEL_PAT  = 2'd1,
    SEL_ICON = 2'd2
  } ram_sel_e;

  typedef struct packed {
    logic two_line;
    logic dbl;
  } line_mode_t;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLEAR,
    OP_HOME,
    OP_SETD,
    OP_SETP,
    OP_SETI,
    OP_ENTRY,
    OP_MOVE,
    OP_MODE,
    OP_WRITE
  } op_e;

endpackage

// File: rtl/cdau_rst_sync.sv
`timescale 1ns/1ps
module cdau_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cdau_stepper.sv
`timescale 1ns/1ps
module cdau_stepper
  import cdau_pkg::*;
#(
  parameter int AW         = 7,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int PAT_AW     = 6,
  parameter int ICON_AW    = 4
) (
  input  logic [AW-1:0] cur,
  input  ram_sel_e      sel,
  input  line_mode_t    mode,
  input  logic          up,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] ONE      = AW'(1);
  localparam logic [AW-1:0] L1_LAST  = AW'(LINE_LEN - 1);
  localparam logic [AW-1:0] L2_BASE  = AW'(LINE2_BASE);
  localparam logic [AW-1:0] L2_LAST  = AW'(LINE2_BASE + LINE_LEN - 1);
  localparam logic [AW-1:0] ONE_LAST = AW'(2 * LINE_LEN - 1);
  localparam logic [PAT_AW-1:0]  PAT_ONE  = PAT_AW'(1);
  localparam logic [ICON_AW-1:0] ICON_ONE = ICON_AW'(1);

  logic [PAT_AW-1:0]  pat_nxt;
  logic [ICON_AW-1:0] icon_nxt;
  logic [AW-1:0]      disp_nxt;

  always_comb begin
    pat_nxt  = up ? cur[PAT_AW-1:0] + PAT_ONE : cur[PAT_AW-1:0] - PAT_ONE;
    icon_nxt = up ? cur[ICON_AW-1:0] + ICON_ONE : cur[ICON_AW-1:0] - ICON_ONE;
  end

  always_comb begin
    disp_nxt = up ? cur + ONE : cur - ONE;
    if (mode.two_line) begin
      if (up) begin
        if (cur == L1_LAST)      disp_nxt = L2_BASE;
        else if (cur == L2_LAST) disp_nxt = '0;
      end else begin
        if (cur == L2_BASE)      disp_nxt = L1_LAST;
        else if (cur == '0)      disp_nxt = L2_LAST;
      end
    end else if (mode.dbl) begin
      if (up && cur == L1_LAST) disp_nxt = '0;
      else if (!up && cur == '0) disp_nxt = L1_LAST;
    end else begin
      if (up && cur == ONE_LAST) disp_nxt = '0;
      else if (!up && cur == '0) disp_nxt = ONE_LAST;
    end
  end

  always_comb begin
    case (sel)
      SEL_PAT:  nxt = {{(AW-PAT_AW){1'b0}}, pat_nxt};
      SEL_ICON: nxt = {{(AW-ICON_AW){1'b0}}, icon_nxt};
      default:  nxt = disp_nxt;
    endcase
  end
endmodule

// File: rtl/cdau_view.sv
`timescale 1ns/1ps
module cdau_view #(
  parameter int LINE_LEN = 40,
  parameter int OFS_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step_en,
  input  logic             step_left,
  input  logic             wide,
  output logic [OFS_W-1:0] ofs
);
  localparam logic [OFS_W-1:0] ONE    = OFS_W'(1);
  localparam logic [OFS_W-1:0] MAX_N  = OFS_W'(LINE_LEN - 1);
  localparam logic [OFS_W-1:0] MAX_W  = OFS_W'(2 * LINE_LEN - 1);

  logic [OFS_W-1:0] ofs_q, ofs_d, top;
  logic             ofs_en;

  always_comb begin
    top    = wide ? MAX_W : MAX_N;
    ofs_en = clr | step_en;
    ofs_d  = ofs_q;
    if (clr)                 ofs_d = '0;
    else if (step_left)      ofs_d = (ofs_q == top) ? '0 : ofs_q + ONE;
    else                     ofs_d = (ofs_q == '0) ? top : ofs_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ofs_q <= '0;
    else if (ofs_en) ofs_q <= ofs_d;
  end

  assign ofs = ofs_q;

  AST_VIEW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ofs_q == '0); // R7

  AST_OFS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_q <= (wide ? MAX_W : MAX_N)); // R8

  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !step_en |=> $stable(ofs_q)); // R10
endmodule

// File: rtl/cdau_ctrl.sv
`timescale 1ns/1ps
module cdau_ctrl
  import cdau_pkg::*;
#(
  parameter int AW         = 7,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int PAT_AW     = 6,
  parameter int ICON_AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_disp_stb,
  input  logic          set_pat_stb,
  input  logic          set_icon_stb,
  input  logic [AW-1:0] set_val,
  input  logic          clear_stb,
  input  logic          home_stb,
  input  logic          entry_stb,
  input  logic          entry_up,
  input  logic          entry_shift,
  input  logic          move_stb,
  input  logic          move_screen,
  input  logic          move_right,
  input  logic          mode_stb,
  input  logic          mode_two_line,
  input  logic          mode_dbl,
  input  logic          wr_stb,
  output logic [AW-1:0] addr,
  output ram_sel_e      sel,
  output logic          inc,
  output logic          view_clr,
  output logic          view_step,
  output logic          view_left,
  output logic          view_wide
);
  localparam logic [AW-1:0] L1_LAST = AW'(LINE_LEN - 1);
  localparam logic [AW-1:0] L2_BASE = AW'(LINE2_BASE);

  op_e        op;
  logic [AW-1:0] addr_q, addr_d, step_nxt;
  ram_sel_e   sel_q, sel_d;
  logic       inc_q, inc_d, shift_q, shift_d;
  line_mode_t mode_q, mode_d;
  logic       upd_en, step_dir;

  // priority decode of the strobes
  always_comb begin
    if (clear_stb)         op = OP_CLEAR;
    else if (home_stb)     op = OP_HOME;
    else if (set_disp_stb) op = OP_SETD;
    else if (set_pat_stb)  op = OP_SETP;
    else if (set_icon_stb) op = OP_SETI;
    else if (entry_stb)    op = OP_ENTRY;
    else if (move_stb)     op = OP_MOVE;
    else if (mode_stb)     op = OP_MODE;
    else if (wr_stb)       op = OP_WRITE;
    else                   op = OP_NONE;
  end

  assign step_dir = (op == OP_MOVE) ? move_right : inc_q;

  cdau_stepper #(
    .AW(AW), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE),
    .PAT_AW(PAT_AW), .ICON_AW(ICON_AW)
  ) u_stepper (
    .cur  (addr_q),
    .sel  (sel_q),
    .mode (mode_q),
    .up   (step_dir),
    .nxt  (step_nxt)
  );

  always_comb begin
    addr_d  = addr_q;
    sel_d   = sel_q;
    inc_d   = inc_q;
    shift_d = shift_q;
    mode_d  = mode_q;
    upd_en  = (op != OP_NONE);
    case (op)
      OP_CLEAR: begin
        addr_d = '0;
        sel_d  = SEL_DISP;
        inc_d  = 1'b1;
      end
      OP_HOME: begin
        addr_d = '0;
        sel_d  = SEL_DISP;
      end
      OP_SETD: begin
        addr_d = set_val;
        sel_d  = SEL_DISP;
      end
      OP_SETP: begin
        addr_d = {{(AW-PAT_AW){1'b0}}, set_val[PAT_AW-1:0]};
        sel_d  = SEL_PAT;
      end
      OP_SETI: begin
        addr_d = {{(AW-ICON_AW){1'b0}}, set_val[ICON_AW-1:0]};
        sel_d  = SEL_ICON;
      end
      OP_ENTRY: begin
        inc_d   = entry_up;
        shift_d = entry_shift;
      end
      OP_MOVE: begin
        if (!move_screen) addr_d = step_nxt;
      end
      OP_MODE: begin
        mode_d.two_line = mode_two_line;
        mode_d.dbl      = mode_dbl;
      end
      OP_WRITE: addr_d = step_nxt;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      sel_q   <= SEL_DISP;
      inc_q   <= 1'b1;
      shift_q <= 1'b0;
      mode_q  <= '0;
    end else if (upd_en) begin
      addr_q  <= addr_d;
      sel_q   <= sel_d;
      inc_q   <= inc_d;
      shift_q <= shift_d;
      mode_q  <= mode_d;
    end
  end

  always_comb begin
    view_clr  = (op == OP_CLEAR) || (op == OP_HOME) || (op == OP_MODE);
    view_step = ((op == OP_MOVE) && move_screen) ||
                ((op == OP_WRITE) && shift_q && (sel_q == SEL_DISP));
    view_left = (op == OP_MOVE) ? !move_right : inc_q;
    view_wide = !mode_q.two_line && !mode_q.dbl;
  end

  assign addr = addr_q;
  assign sel  = sel_q;
  assign inc  = inc_q;

  AST_CLEAR_HOMES_UP: assert property (@(posedge clk) disable iff (!rst_n)
    clear_stb |=> addr_q == '0 && inc_q && sel_q == SEL_DISP); // R7

  AST_SEL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_disp_stb || set_pat_stb || set_icon_stb || clear_stb || home_stb)
      |=> $stable(sel_q)); // R2

  AST_LINE_SEAM_UP: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_WRITE && sel_q == SEL_DISP && mode_q.two_line && inc_q &&
    addr_q == L1_LAST |=> addr_q == L2_BASE); // R4

  AST_LINE_SEAM_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_WRITE && sel_q == SEL_DISP && mode_q.two_line && !inc_q &&
    addr_q == L2_BASE |=> addr_q == L1_LAST); // R4

  AST_ICON_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q == SEL_ICON |-> addr_q[AW-1:ICON_AW] == '0); // R6

  AST_SCREEN_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_MOVE && move_screen |=> $stable(addr_q)); // R9

  AST_WRITE_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && entry_stb && !clear_stb && !home_stb && !set_disp_stb &&
    !set_pat_stb && !set_icon_stb |=> $stable(addr_q)); // R12
endmodule

// File: rtl/chardisp_addr_unit.sv
`timescale 1ns/1ps
module chardisp_addr_unit
  import cdau_pkg::*;
#(
  parameter int AW         = 7,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int PAT_AW     = 6,
  parameter int ICON_AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_disp_stb,
  input  logic          set_pat_stb,
  input  logic          set_icon_stb,
  input  logic [AW-1:0] set_val,
  input  logic          clear_stb,
  input  logic          home_stb,
  input  logic          entry_stb,
  input  logic          entry_up,
  input  logic          entry_shift,
  input  logic          move_stb,
  input  logic          move_screen,
  input  logic          move_right,
  input  logic          mode_stb,
  input  logic          mode_two_line,
  input  logic          mode_dbl,
  input  logic          wr_stb,
  output logic [AW-1:0] addr,
  output logic [1:0]    ram_sel,
  output logic          step_up,
  output logic [6:0]    view_ofs
);
  localparam int OFS_W = $clog2(2 * LINE_LEN);

  logic       rst_sync_n;
  ram_sel_e   sel;
  logic       view_clr, view_step, view_left, view_wide;
  logic [OFS_W-1:0] ofs;

  cdau_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cdau_ctrl #(
    .AW(AW), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE),
    .PAT_AW(PAT_AW), .ICON_AW(ICON_AW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .set_disp_stb  (set_disp_stb),
    .set_pat_stb   (set_pat_stb),
    .set_icon_stb  (set_icon_stb),
    .set_val       (set_val),
    .clear_stb     (clear_stb),
    .home_stb      (home_stb),
    .entry_stb     (entry_stb),
    .entry_up      (entry_up),
    .entry_shift   (entry_shift),
    .move_stb      (move_stb),
    .move_screen   (move_screen),
    .move_right    (move_right),
    .mode_stb      (mode_stb),
    .mode_two_line (mode_two_line),
    .mode_dbl      (mode_dbl),
    .wr_stb        (wr_stb),
    .addr          (addr),
    .sel           (sel),
    .inc           (step_up),
    .view_clr      (view_clr),
    .view_step     (view_step),
    .view_left     (view_left),
    .view_wide     (view_wide)
  );

  cdau_view #(
    .LINE_LEN (LINE_LEN),
    .OFS_W    (OFS_W)
  ) u_view (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (view_clr),
    .step_en   (view_step),
    .step_left (view_left),
    .wide      (view_wide),
    .ofs       (ofs)
  );

  assign ram_sel  = sel;
  assign view_ofs = 7'(ofs);
endmodule

// File: tb/test_chardisp_addr_unit.sv
`timescale 1ns/1ps
module test_chardisp_addr_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic set_disp_stb, set_pat_stb, set_icon_stb;
  logic [6:0] set_val;
  logic clear_stb, home_stb, entry_stb, entry_up, entry_shift;
  logic move_stb, move_screen, move_right;
  logic mode_stb, mode_two_line, mode_dbl, wr_stb;
  logic [6:0] addr;
  logic [1:0] ram_sel;
  logic       step_up;
  logic [6:0] view_ofs;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  chardisp_addr_unit i_chardisp_addr_unit (
    .clk(clk), .rst_n(rst_n),
    .set_disp_stb(set_disp_stb), .set_pat_stb(set_pat_stb),
    .set_icon_stb(set_icon_stb), .set_val(set_val),
    .clear_stb(clear_stb), .home_stb(home_stb),
    .entry_stb(entry_stb), .entry_up(entry_up), .entry_shift(entry_shift),
    .move_stb(move_stb), .move_screen(move_screen), .move_right(move_right),
    .mode_stb(mode_stb), .mode_two_line(mode_two_line), .mode_dbl(mode_dbl),
    .wr_stb(wr_stb),
    .addr(addr), .ram_sel(ram_sel), .step_up(step_up), .view_ofs(view_ofs)
  );

  task automatic idle();
    set_disp_stb = 0; set_pat_stb = 0; set_icon_stb = 0; set_val = '0;
    clear_stb = 0; home_stb = 0; entry_stb = 0; entry_up = 0; entry_shift = 0;
    move_stb = 0; move_screen = 0; move_right = 0;
    mode_stb = 0; mode_two_line = 0; mode_dbl = 0; wr_stb = 0;
  endtask

  task automatic fire();
    @(negedge clk);
    idle();
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_set(int kind, int v);
    set_val = 7'(v);
    if (kind == 0) set_disp_stb = 1;
    else if (kind == 1) set_pat_stb = 1;
    else set_icon_stb = 1;
    fire();
  endtask
  task automatic do_write();                 wr_stb = 1; fire(); endtask
  task automatic do_entry(int up, int sh);   entry_stb = 1; entry_up = 1'(up); entry_shift = 1'(sh); fire(); endtask
  task automatic do_move(int scr, int rt);   move_stb = 1; move_screen = 1'(scr); move_right = 1'(rt); fire(); endtask
  task automatic do_mode(int two, int dbl);  mode_stb = 1; mode_two_line = 1'(two); mode_dbl = 1'(dbl); fire(); endtask
  task automatic do_clear();                 clear_stb = 1; fire(); endtask
  task automatic do_home();                  home_stb = 1; fire(); endtask

  // expected next address, by linear position arithmetic
  function automatic int exp_step(int a, int sel, int two, int dbl, int up);
    int idx;
    if (sel == 1) return (a + (up != 0 ? 1 : 63)) % 64;
    if (sel == 2) return (a + (up != 0 ? 1 : 15)) % 16;
    if (two != 0) begin
      idx = (a >= 64) ? a - 64 + 40 : a;
      idx = (idx + (up != 0 ? 1 : 79)) % 80;
      return (idx >= 40) ? idx - 40 + 64 : idx;
    end
    if (dbl != 0) return (a + (up != 0 ? 1 : 39)) % 40;
    return (a + (up != 0 ? 1 : 79)) % 80;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a;
    string tag;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 addr", int'(addr), 0);
    chk("R1 sel", int'(ram_sel), 0);
    chk("R1 dir", int'(step_up), 1);
    chk("R1 ofs", int'(view_ofs), 0);
    do_write();
    chk("R1 one-line step", int'(addr), 1);
    chk("R1 shift off", int'(view_ofs), 0);

    // R3 R4 R5 R10 display sweeps in each layout and direction
    for (int m = 0; m < 3; m++) begin
      int two, dbl;
      two = (m == 2) ? 1 : 0;
      dbl = (m == 1) ? 1 : 0;
      tag = (m == 0) ? "R3" : (m == 1) ? "R5" : "R4";
      do_mode(two, dbl);
      chk("R11 ofs cleared", int'(view_ofs), 0);
      for (int d = 0; d < 2; d++) begin
        do_entry(d, 0);
        for (int k = 0; k < 80; k++) begin
          if (m == 1 && k >= 40) continue;
          a = (m == 2 && k >= 40) ? k - 40 + 64 : k;
          do_set(0, a);
          do_write();
          chk(tag, int'(addr), exp_step(a, 0, two, dbl, d));
          do_set(0, a);
          do_move(0, d);
          chk("R10 cursor", int'(addr), exp_step(a, 0, two, dbl, d));
        end
      end
    end

    // R6 pattern and icon sweeps, R2 masking and select
    for (int d = 0; d < 2; d++) begin
      do_entry(d, 0);
      for (int k = 0; k < 64; k++) begin
        do_set(1, k + 64 * (k % 2));
        chk("R2 pat load", int'(addr), k);
        do_write();
        chk("R6 pat", int'(addr), exp_step(k, 1, 0, 0, d));
        chk("R2 pat sel", int'(ram_sel), 1);
      end
      for (int k = 0; k < 16; k++) begin
        do_set(2, k + 16 * (k % 8));
        chk("R2 icon load", int'(addr), k);
        do_write();
        chk("R6 icon", int'(addr), exp_step(k, 2, 0, 0, d));
        chk("R2 icon sel", int'(ram_sel), 2);
      end
    end

    // R2 select persists across entry, cursor move and layout
    do_set(2, 3);
    do_entry(1, 1);
    do_move(0, 1);
    do_mode(0, 0);
    do_write();
    chk("R2 persist sel", int'(ram_sel), 2);
    chk("R2 persist addr", int'(addr), 5);
    chk("R8 icon no shift", int'(view_ofs), 0);

    // R8 write and shift in the same cycle at the line seam
    do_mode(1, 0);
    do_entry(1, 1);
    do_set(0, 39);
    do_write();
    chk("R8 seam addr", int'(addr), 64);
    chk("R8 seam ofs", int'(view_ofs), 1);
    do_entry(0, 1);
    do_write();
    chk("R8 back addr", int'(addr), 39);
    chk("R8 back ofs", int'(view_ofs), 0);
    do_write();
    chk("R8 wrap addr", int'(addr), 38);
    chk("R8 wrap ofs", int'(view_ofs), 39);
    do_set(1, 5);
    do_write();
    chk("R8 pat addr", int'(addr), 4);
    chk("R8 pat no shift", int'(view_ofs), 39);

    // R9 screen shift
    do_move(1, 1);
    chk("R9 right ofs", int'(view_ofs), 38);
    chk("R9 addr kept", int'(addr), 4);
    do_move(1, 0);
    do_move(1, 0);
    chk("R9 left wrap", int'(view_ofs), 0);
    chk("R9 addr kept2", int'(addr), 4);

    // R7 home and clear
    do_move(1, 0);
    do_home();
    chk("R7 home addr", int'(addr), 0);
    chk("R7 home sel", int'(ram_sel), 0);
    chk("R7 home ofs", int'(view_ofs), 0);
    chk("R7 home dir kept", int'(step_up), 0);
    do_move(1, 0);
    do_set(1, 9);
    do_clear();
    chk("R7 clear addr", int'(addr), 0);
    chk("R7 clear dir", int'(step_up), 1);
    chk("R7 clear sel", int'(ram_sel), 0);
    chk("R7 clear ofs", int'(view_ofs), 0);

    // R11 window width follows layout
    do_mode(0, 0);
    do_move(1, 1);
    chk("R11 wide window", int'(view_ofs), 79);
    do_mode(0, 1);
    chk("R11 mode clears", int'(view_ofs), 0);
    do_move(1, 1);
    chk("R11 narrow window", int'(view_ofs), 39);
    do_mode(1, 1);
    do_set(0, 103);
    do_entry(1, 0);
    do_write();
    chk("R11 two-line wins", int'(addr), 0);

    // R12 collisions
    do_set(0, 5);
    clear_stb = 1; wr_stb = 1; fire();
    chk("R12 clear over write", int'(addr), 0);
    set_disp_stb = 1; set_pat_stb = 1; set_val = 7'd10; fire();
    chk("R12 disp over pat sel", int'(ram_sel), 0);
    chk("R12 disp over pat addr", int'(addr), 10);
    entry_stb = 1; entry_up = 0; wr_stb = 1; fire();
    chk("R12 write dropped", int'(addr), 10);
    chk("R12 entry taken", int'(step_up), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule